// File: doc/BRIEF.md
# Z80 Bus Cycle Classifier

This block is a passive observer placed beside an 8-bit Z80-style processor bus. It samples the active-low strobes (M1, MREQ, IORQ, RD, WR, RFSH), the 16-bit address and the 8-bit data lines on every rising clock edge. It never drives any of them. Each completed machine cycle becomes one record. The record carries the cycle type, the address that matters for that type, the data byte seen on the bus and a flag for opcode fetches that follow a prefix byte.

The monitor remembers whether the last opcode byte fetched was a prefix. Every M1 fetch of a multi-byte opcode is therefore tagged, even when operand reads fall between the fetches. An M1 strobe that comes together with IORQ is reported as an interrupt acknowledge, never as a fetch or a port access. The monitor suits trace capture, coverage collection and protocol checking in a system built around such a processor. All bus inputs are assumed synchronous to the monitor clock.

Top module: `zbus_cycle_tagger`

## Requirements
- R1: After reset, `rec_valid` is 0 and every record field reads 0 until a machine cycle completes.
- R2: A machine cycle is the run of samples in which MREQ or IORQ is low. Consecutive cycles are separated by at least one sample with both high. The record is presented on the first edge that samples both strobes high again, and `rec_valid` is high for exactly one clock.
- R3: Each sample is classified with this priority:
  - M1 and IORQ low: interrupt acknowledge, code 6.
  - MREQ and RFSH low: refresh, code 7.
  - MREQ and M1 low: opcode fetch, code 0, or code 1 when prefixed.
  - MREQ and RD low: memory read, code 2.
  - MREQ and WR low: memory write, code 3.
  - IORQ and RD low: port read, code 4.
  - IORQ and WR low: port write, code 5.
- R4: For codes 0 to 3, `rec_addr` is the full 16-bit bus address, covering a 64K-byte space.
- R5: For codes 4 and 5, `rec_addr[7:0]` is the port number, taken from address bits 7:0, and bits 15:8 are 0.
- R6: For code 7, `rec_addr[6:0]` holds address bits 6:0 and bits 15:7 are 0.
- R7: For code 6, `rec_addr` is 0 and `rec_data` is the byte the responding device places on the data bus.
- R8: `rec_data` is the data-bus byte at the last classified sample of the cycle. This holds for read and write cycles alike, so earlier values within the cycle are discarded.
- R9: A fetch whose byte is CBh, DDh, EDh or FDh arms the prefix state. The next fetch is reported with code 1 and `rec_prefixed` set to 1. Every other record has `rec_prefixed` set to 0.
- R10: The armed prefix state has these rules:
  - It survives memory, port and refresh records.
  - It stays armed when one prefix follows another.
  - It is cleared by a fetch of a non-prefix byte, by an interrupt acknowledge and by reset.
- R11: A cycle in which no sample meets any R3 condition produces no record. Samples before the cycle qualifies have no effect on the record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock; bus sampled on rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| m1_n | input | 1 | Opcode-fetch strobe, active low |
| mreq_n | input | 1 | Memory request strobe, active low |
| iorq_n | input | 1 | Port request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rfsh_n | input | 1 | Refresh strobe, active low |
| bus_addr | input | 16 | Address bus, bit 0 least significant |
| bus_data | input | 8 | Data bus as observed |
| rec_valid | output | 1 | One-clock record strobe |
| rec_kind | output | 3 | Cycle type code (R3) |
| rec_addr | output | 16 | Effective address of the cycle |
| rec_data | output | 8 | Data byte of the cycle |
| rec_prefixed | output | 1 | Fetch follows a prefix byte |

## Verification
The checker module checks the following on every cycle:
- the single-clock record pulse, and that it appears only after both request strobes have gone high;
- that port, refresh and interrupt-acknowledge records carry zero in their unused upper address bits;
- that the prefixed flag agrees with a prefix model driven from the record stream.

Only the bench scenarios can show that the classification priority holds for overlapping strobes, that the last classified data byte wins, and that unqualified cycles are dropped. The same applies to the prefix state surviving interleaved operand reads and being cleared by interrupt acknowledge and by reset.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

   typedef enum logic [2:0] {
      ZK_FETCH   = 3'd0,
      ZK_PFETCH  = 3'd1,
      ZK_MEMRD   = 3'd2,
      ZK_MEMWR   = 3'd3,
      ZK_IORD    = 3'd4,
      ZK_IOWR    = 3'd5,
      ZK_INTACK  = 3'd6,
      ZK_REFRESH = 3'd7
   } zk_kind_e;

   // Opcode bytes that announce a further M1 fetch
   function automatic logic zk_is_prefix(input logic [7:0] b);
      return (b == 8'hCB) || (b == 8'hDD) || (b == 8'hED) || (b == 8'hFD);
   endfunction

endpackage

// File: rtl/zbt_sampler.sv
module zbt_sampler #(
   parameter int WIDTH  = 1,
   parameter int IN_REG = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (IN_REG != 0) begin : g_reg
         logic [WIDTH-1:0] stage_q;
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q <= '1;   // all strobes idle
            else        stage_q <= d;
         end
         assign q = stage_q;
      end else begin : g_thru
         logic unused_clk_rst;
         assign unused_clk_rst = clk ^ rst_n;
         assign q = d;
      end
   endgenerate

endmodule

// File: rtl/zbt_classify.sv
module zbt_classify
   import zbt_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int PORT_W = 8,
   parameter int RFSH_W = 7
) (
   input  logic              m1_n,
   input  logic              mreq_n,
   input  logic              iorq_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic              rfsh_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              active,
   output logic              hit,
   output zk_kind_e          kind,
   output logic [ADDR_W-1:0] eff_addr
);

   always_comb begin
      active   = !mreq_n || !iorq_n;
      hit      = 1'b1;
      kind     = ZK_FETCH;
      eff_addr = addr;
      if (!iorq_n && !m1_n) begin
         kind     = ZK_INTACK;
         eff_addr = '0;
      end else if (!mreq_n && !rfsh_n) begin
         kind                 = ZK_REFRESH;
         eff_addr             = '0;
         eff_addr[RFSH_W-1:0] = addr[RFSH_W-1:0];
      end else if (!mreq_n && !m1_n) begin
         kind = ZK_FETCH;
      end else if (!mreq_n && !rd_n) begin
         kind = ZK_MEMRD;
      end else if (!mreq_n && !wr_n) begin
         kind = ZK_MEMWR;
      end else if (!iorq_n && !rd_n) begin
         kind                 = ZK_IORD;
         eff_addr             = '0;
         eff_addr[PORT_W-1:0] = addr[PORT_W-1:0];
      end else if (!iorq_n && !wr_n) begin
         kind                 = ZK_IOWR;
         eff_addr             = '0;
         eff_addr[PORT_W-1:0] = addr[PORT_W-1:0];
      end else begin
         hit = 1'b0;
      end
   end

endmodule

// File: rtl/zbt_capture.sv
module zbt_capture
   import zbt_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              hit,
   input  zk_kind_e          kind,
   input  logic [ADDR_W-1:0] eff_addr,
   input  logic [DATA_W-1:0] data,
   input  logic              pfx_armed,
   output logic              rec_valid,
   output zk_kind_e          rec_kind,
   output logic [ADDR_W-1:0] rec_addr,
   output logic [DATA_W-1:0] rec_data,
   output logic              rec_prefixed
);

   logic              got_q;
   zk_kind_e          kind_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              is_fetch;

   assign is_fetch = (kind_q == ZK_FETCH);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         got_q        <= 1'b0;
         kind_q       <= ZK_FETCH;
         addr_q       <= '0;
         data_q       <= '0;
         rec_valid    <= 1'b0;
         rec_kind     <= ZK_FETCH;
         rec_addr     <= '0;
         rec_data     <= '0;
         rec_prefixed <= 1'b0;
      end else begin
         rec_valid <= 1'b0;
         if (active) begin
            if (hit) begin
               got_q  <= 1'b1;
               kind_q <= kind;
               addr_q <= eff_addr;
               data_q <= data;
            end
         end else begin
            got_q <= 1'b0;
            if (got_q) begin
               rec_valid    <= 1'b1;
               rec_kind     <= (is_fetch && pfx_armed) ? ZK_PFETCH : kind_q;
               rec_prefixed <= is_fetch && pfx_armed;
               rec_addr     <= addr_q;
               rec_data     <= data_q;
            end
         end
      end
   end

endmodule

// File: rtl/zbt_prefix_track.sv
module zbt_prefix_track
   import zbt_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rec_valid,
   input  zk_kind_e          rec_kind,
   input  logic [DATA_W-1:0] rec_data,
   output logic              armed
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed <= 1'b0;
      end else if (rec_valid) begin
         case (rec_kind)
            ZK_FETCH, ZK_PFETCH: armed <= zk_is_prefix(rec_data[7:0]);
            ZK_INTACK:           armed <= 1'b0;
            default:             armed <= armed;
         endcase
      end
   end

endmodule

// File: rtl/zbus_cycle_tagger.sv
module zbus_cycle_tagger
   import zbt_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int PORT_W = 8,
   parameter int RFSH_W = 7,
   parameter int IN_REG = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              m1_n,
   input  logic              mreq_n,
   input  logic              iorq_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic              rfsh_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data,
   output logic              rec_valid,
   output logic [2:0]        rec_kind,
   output logic [ADDR_W-1:0] rec_addr,
   output logic [DATA_W-1:0] rec_data,
   output logic              rec_prefixed
);

   localparam int CTRL_W = 6;
   localparam int BUS_W  = CTRL_W + ADDR_W + DATA_W;

   generate
      if (DATA_W < 8) begin : g_bad_data
         $error("DATA_W must be at least 8");
      end
      if (PORT_W < 1 || PORT_W > ADDR_W) begin : g_bad_port
         $error("PORT_W must lie in 1..ADDR_W");
      end
      if (RFSH_W < 1 || RFSH_W > ADDR_W) begin : g_bad_rfsh
         $error("RFSH_W must lie in 1..ADDR_W");
      end
      if (IN_REG != 0 && IN_REG != 1) begin : g_bad_inreg
         $error("IN_REG must be 0 or 1");
      end
   endgenerate

   logic [BUS_W-1:0]  raw_bus, smp_bus;
   logic              s_m1_n, s_mreq_n, s_iorq_n, s_rd_n, s_wr_n, s_rfsh_n;
   logic [ADDR_W-1:0] s_addr;
   logic [DATA_W-1:0] s_data;

   assign raw_bus = {m1_n, mreq_n, iorq_n, rd_n, wr_n, rfsh_n, bus_addr, bus_data};

   zbt_sampler #(.WIDTH(BUS_W), .IN_REG(IN_REG)) u_sampler (
      .clk (clk),
      .rst_n (rst_n),
      .d (raw_bus),
      .q (smp_bus)
   );

   assign {s_m1_n, s_mreq_n, s_iorq_n, s_rd_n, s_wr_n, s_rfsh_n} = smp_bus[BUS_W-1 -: CTRL_W];
   assign s_addr = smp_bus[DATA_W +: ADDR_W];
   assign s_data = smp_bus[DATA_W-1:0];

   logic              c_active, c_hit;
   zk_kind_e          c_kind;
   logic [ADDR_W-1:0] c_addr;

   zbt_classify #(.ADDR_W(ADDR_W), .PORT_W(PORT_W), .RFSH_W(RFSH_W)) u_classify (
      .m1_n (s_m1_n),
      .mreq_n (s_mreq_n),
      .iorq_n (s_iorq_n),
      .rd_n (s_rd_n),
      .wr_n (s_wr_n),
      .rfsh_n (s_rfsh_n),
      .addr (s_addr),
      .active (c_active),
      .hit (c_hit),
      .kind (c_kind),
      .eff_addr (c_addr)
   );

   logic     pfx_armed;
   zk_kind_e k_rec;

   zbt_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_capture (
      .clk (clk),
      .rst_n (rst_n),
      .active (c_active),
      .hit (c_hit),
      .kind (c_kind),
      .eff_addr (c_addr),
      .data (s_data),
      .pfx_armed (pfx_armed),
      .rec_valid (rec_valid),
      .rec_kind (k_rec),
      .rec_addr (rec_addr),
      .rec_data (rec_data),
      .rec_prefixed (rec_prefixed)
   );

   zbt_prefix_track #(.DATA_W(DATA_W)) u_prefix (
      .clk (clk),
      .rst_n (rst_n),
      .rec_valid (rec_valid),
      .rec_kind (k_rec),
      .rec_data (rec_data),
      .armed (pfx_armed)
   );

   assign rec_kind = k_rec;

endmodule

// File: rtl/zbt_checker.sv
module zbt_checker
   import zbt_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int PORT_W = 8,
   parameter int RFSH_W = 7,
   parameter int IN_REG = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mreq_n,
   input logic              iorq_n,
   input logic              rec_valid,
   input logic [2:0]        rec_kind,
   input logic [ADDR_W-1:0] rec_addr,
   input logic [DATA_W-1:0] rec_data,
   input logic              rec_prefixed
);

   logic is_io, is_fetch, idle;
   logic model_armed;

   assign is_io    = (rec_kind == ZK_IORD) || (rec_kind == ZK_IOWR);
   assign is_fetch = (rec_kind == ZK_FETCH) || (rec_kind == ZK_PFETCH);
   assign idle     = mreq_n && iorq_n;

   // Independent prefix model fed only by the record stream
   always_ff @(posedge clk) begin
      if (!rst_n) model_armed <= 1'b0;
      else if (rec_valid && is_fetch) model_armed <= zk_is_prefix(rec_data[7:0]);
      else if (rec_valid && rec_kind == ZK_INTACK) model_armed <= 1'b0;
   end

   AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid |=> !rec_valid); // R2

   generate
      if (IN_REG != 0) begin : g_lat2
         AST_EMIT_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
            rec_valid |-> $past(idle, 2)); // R2
      end else begin : g_lat1
         AST_EMIT_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
            rec_valid |-> $past(idle)); // R2
      end
   endgenerate

   AST_PORT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && is_io) |-> ((rec_addr >> PORT_W) == '0)); // R5

   AST_RFSH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && rec_kind == ZK_REFRESH) |-> ((rec_addr >> RFSH_W) == '0)); // R6

   AST_INTACK_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && rec_kind == ZK_INTACK) |-> (rec_addr == '0)); // R7

   AST_PREFIX_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && is_fetch) |-> (rec_prefixed == model_armed)); // R9

   AST_FLAG_ONLY_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && !is_fetch) |-> !rec_prefixed); // R9

endmodule

bind zbus_cycle_tagger zbt_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_W(PORT_W), .RFSH_W(RFSH_W), .IN_REG(IN_REG)
) u_zbt_checker (
   .clk (clk),
   .rst_n (rst_n),
   .mreq_n (mreq_n),
   .iorq_n (iorq_n),
   .rec_valid (rec_valid),
   .rec_kind (rec_kind),
   .rec_addr (rec_addr),
   .rec_data (rec_data),
   .rec_prefixed (rec_prefixed)
);

// File: tb/tb_zbus_cycle_tagger.sv
module tb_zbus_cycle_tagger;

   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n;
   logic m1_n, mreq_n, iorq_n, rd_n, wr_n, rfsh_n;
   logic [15:0] bus_addr;
   logic [7:0]  bus_data;
   logic        rec_valid, rec_prefixed;
   logic [2:0]  rec_kind;
   logic [15:0] rec_addr;
   logic [7:0]  rec_data;

   int n_chk  = 0;
   int n_fail = 0;
   bit pend   = 1'b0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   zbus_cycle_tagger dut (
      .clk (clk), .rst_n (rst_n),
      .m1_n (m1_n), .mreq_n (mreq_n), .iorq_n (iorq_n),
      .rd_n (rd_n), .wr_n (wr_n), .rfsh_n (rfsh_n),
      .bus_addr (bus_addr), .bus_data (bus_data),
      .rec_valid (rec_valid), .rec_kind (rec_kind), .rec_addr (rec_addr),
      .rec_data (rec_data), .rec_prefixed (rec_prefixed)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic int exp_kind(bit m1, bit mq, bit io, bit rd, bit wr, bit rf);
      if (!io && !m1) return 6;
      if (!mq && !rf) return 7;
      if (!mq && !m1) return 0;
      if (!mq && !rd) return 2;
      if (!mq && !wr) return 3;
      if (!io && !rd) return 4;
      if (!io && !wr) return 5;
      return -1;
   endfunction

   function automatic logic [15:0] exp_addr(int k, logic [15:0] a);
      case (k)
         4, 5:    return {8'h00, a[7:0]};
         6:       return 16'h0000;
         7:       return {9'h000, a[6:0]};
         default: return a;
      endcase
   endfunction

   function automatic bit is_pfx(logic [7:0] b);
      return b == 8'hCB || b == 8'hDD || b == 8'hED || b == 8'hFD;
   endfunction

   task automatic bus_idle();
      m1_n = 1; mreq_n = 1; iorq_n = 1; rd_n = 1; wr_n = 1; rfsh_n = 1;
   endtask

   task automatic do_reset();
      bus_idle();
      bus_addr = '0; bus_data = '0;
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      pend = 0;
   endtask

   task automatic run_cycle(input bit m1, input bit mq, input bit io, input bit rd, input bit wr,
                            input bit rf, input logic [15:0] a, input logic [7:0] d,
                            input int hold, input bit stagger);
      int k;
      int ek;
      k = exp_kind(m1, mq, io, rd, wr, rf);
      if (stagger) begin
         bus_idle(); mreq_n = mq; iorq_n = io;
         bus_addr = a; bus_data = ~d;
         @(negedge clk);
      end
      for (int i = 0; i < hold; i++) begin
         m1_n = m1; mreq_n = mq; iorq_n = io; rd_n = rd; wr_n = wr; rfsh_n = rf;
         bus_addr = a;
         bus_data = (i == hold - 1) ? d : (d ^ 8'h5A);
         @(negedge clk);
      end
      bus_idle();
      bus_addr = 16'($urandom); bus_data = 8'($urandom);
      @(negedge clk);
      if (k < 0) begin
         chk(rec_valid == 1'b0, "R11 unqualified cycle gave record", rec_valid, 0);
      end else begin
         ek = (k == 0 && pend) ? 1 : k;
         chk(rec_valid == 1'b1, "R2 record strobe", rec_valid, 1);
         chk(rec_kind == 3'(ek), "R3 kind", rec_kind, ek);
         chk(rec_addr == exp_addr(k, a),
             (k < 4) ? "R4 memory address" : (k < 6) ? "R5 port number" :
             (k == 6) ? "R7 intack address" : "R6 refresh address",
             rec_addr, exp_addr(k, a));
         chk(rec_data == d, (k == 6) ? "R7 vector byte" : "R8 data byte", rec_data, d);
         chk(rec_prefixed == (ek == 1), "R9 prefixed flag", rec_prefixed, (ek == 1));
         if (k == 0) pend = is_pfx(d);
         else if (k == 6) pend = 0;
      end
      @(negedge clk);
      chk(rec_valid == 1'b0, "R2 single-clock pulse", rec_valid, 0);
   endtask

   // shorthand wrappers: strobes given active low
   task automatic fetch(input logic [15:0] a, input logic [7:0] d);
      run_cycle(0, 0, 1, 0, 1, 1, a, d, 1, 0);
   endtask
   task automatic intack(input logic [7:0] d);
      run_cycle(0, 1, 0, 1, 1, 1, 16'h1234, d, 2, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL R2 watchdog expired: actual 0 expected 1");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd24681));
      do_reset();
      // R1 reset state
      chk(rec_valid == 0, "R1 valid after reset", rec_valid, 0);
      chk(rec_kind == 0, "R1 kind after reset", rec_kind, 0);
      chk(rec_addr == 0, "R1 addr after reset", rec_addr, 0);
      chk(rec_data == 0, "R1 data after reset", rec_data, 0);
      chk(rec_prefixed == 0, "R1 flag after reset", rec_prefixed, 0);

      // one cycle of each type
      fetch(16'h0000, 8'h3E);
      run_cycle(1, 0, 1, 0, 1, 1, 16'hFFFF, 8'hA5, 2, 1);   // memory read, R4 R8
      run_cycle(1, 0, 1, 1, 0, 1, 16'h8001, 8'h5C, 3, 1);   // memory write
      run_cycle(1, 1, 0, 0, 1, 1, 16'hAB12, 8'h77, 2, 0);   // port read, R5
      run_cycle(1, 1, 0, 1, 0, 1, 16'h34FE, 8'h19, 2, 1);   // port write
      run_cycle(1, 0, 1, 1, 1, 0, 16'hFFFF, 8'h00, 1, 0);   // refresh, R6
      intack(8'hFF);                                        // R7

      // R3 priority among overlapping strobes
      run_cycle(0, 1, 0, 0, 1, 1, 16'h00C3, 8'h42, 1, 0);   // intack beats port read
      run_cycle(0, 0, 1, 0, 1, 0, 16'h1280, 8'h11, 1, 0);   // refresh beats fetch
      run_cycle(0, 0, 1, 0, 0, 1, 16'h4000, 8'h22, 1, 0);   // fetch beats read/write
      run_cycle(1, 0, 1, 0, 0, 1, 16'h4001, 8'h33, 1, 0);   // read beats write

      // R11 cycles that never qualify
      run_cycle(1, 0, 1, 1, 1, 1, 16'h5555, 8'h44, 2, 0);
      run_cycle(1, 1, 0, 1, 1, 1, 16'h6666, 8'h55, 1, 0);

      // R9 simple prefix
      fetch(16'h0100, 8'hCB);
      fetch(16'h0101, 8'h07);
      // R10 survives operand read and refresh
      fetch(16'h0200, 8'hDD);
      run_cycle(1, 0, 1, 0, 1, 1, 16'h0201, 8'h05, 1, 0);
      run_cycle(1, 0, 1, 1, 1, 0, 16'h007F, 8'h00, 1, 0);
      fetch(16'h0202, 8'h21);
      // R10 chained prefixes
      fetch(16'h0300, 8'hDD);
      fetch(16'h0301, 8'hFD);
      fetch(16'h0302, 8'h21);
      // R10 cleared by interrupt acknowledge
      fetch(16'h0400, 8'hED);
      intack(8'hFF);
      fetch(16'h0038, 8'h00);
      // R10 cleared by reset
      fetch(16'h0500, 8'hFD);
      do_reset();
      fetch(16'h0000, 8'h00);

      // constrained random traffic
      for (int n = 0; n < 400; n++) begin
         bit m1, mq, io, rd, wr, rf;
         int sel;
         logic [7:0] d;
         sel = int'($urandom % 8);
         mq = (sel == 5 || sel == 6);
         io = (sel < 5);
         m1 = ($urandom % 10) >= 3;
         rd = ($urandom % 10) >= 4;
         wr = ($urandom % 10) >= 4;
         rf = ($urandom % 10) >= 2;
         d  = 8'($urandom);
         if (!m1 && ($urandom % 3 == 0)) begin
            case ($urandom % 4)
               0: d = 8'hCB;
               1: d = 8'hDD;
               2: d = 8'hED;
               default: d = 8'hFD;
            endcase
         end
         run_cycle(m1, mq, io, rd, wr, rf, 16'($urandom), d,
                   1 + int'($urandom % 3), bit'($urandom % 2));
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule